// File: doc/BRIEF.md
# Watchdog Control Register Front End

This block is the control-register front end of a watchdog timer. It lives on a simple register bus in the bus clock domain. It holds three control bits: a sticky lock bit that keeps the watchdog running, a window-mode select bit and an enable bit. When the bus domain is reset, all three bits take their values from a non-volatile configuration byte instead of from fixed constants.

The effective enable is the enable bit OR the lock bit. This value is carried into the watchdog clock domain by a toggle request, and the request's return is acknowledged through a second synchronizer. A busy flag in the status register stays up from the write until the watchdog side has taken the new value. While locked, the block ignores control writes and drops two write-permit outputs. These outputs gate the configuration and early-warning registers, which sit outside this block.

Top module: `wdog_ctrl_front`

## Requirements
- R1: The control register is at bus address 0. The lock bit is bit 7, window-select is bit 2 and enable is bit 1. Bits 6..3 and bit 0 read as zero, and writing them has no effect. Unmapped address 2 reads as zero.
- R2: While rst_bus is high, lock, window-select and enable load from nvm_ctrl bits 7, 2 and 1 respectively.
- R3: Writing 1 to bit 7 sets the lock. Writing 0 to bit 7 has no effect. Only rst_bus clears the lock.
- R4: While the lock is set, wd_enable settles to 1 whatever value the enable bit holds.
- R5: While the lock is set, writes to the control register change nothing, and cfg_wr_permit and ew_wr_permit are 0. While the lock is clear, both permits are 1.
- R6: An enable write is accepted only while the lock is clear and SYNCBUSY is 0. A write that arrives while SYNCBUSY is set leaves the enable bit at its pending value.
- R7: A read returns data in bus_rdata on the cycle after bus_rd. An accepted control write is seen on the next read. The status register is at address 1 and is read-only. Its bit 7 is SYNCBUSY, and its bits 6..0 read as zero. SYNCBUSY is 1 from the cycle after a write that changes the effective enable until the change is acknowledged. A write that does not change the effective enable leaves SYNCBUSY at 0.
- R8: wd_window follows the window-select bit as a level. 0 selects normal mode and 1 selects window mode.
- R9: After a change of the effective enable, wd_enable takes the new value and SYNCBUSY clears within 8 watchdog clock cycles, provided the bus clock is at least as fast as the watchdog clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus domain clock |
| rst_bus | input | 1 | Synchronous active-high power-on reset, bus domain |
| clk_wd | input | 1 | Watchdog domain clock |
| rst_wd | input | 1 | Synchronous active-high reset, watchdog domain |
| nvm_ctrl | input | 8 | Power-up image of the control bits, loaded during reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| wd_enable | output | 1 | Effective enable in the watchdog domain |
| wd_window | output | 1 | Window-mode select level |
| cfg_wr_permit | output | 1 | Write permit for the configuration register |
| ew_wr_permit | output | 1 | Write permit for the early-warning register |

## Verification
The enable path is exercised with several kinds of write:
- A plain enable toggle, which must raise SYNCBUSY, then clear it within the bound while wd_enable follows.
- A pair of back-to-back enable writes, where the second lands while busy and must be dropped.
- A window-only write, which must change wd_window without starting a transfer.
- A write with every reserved bit set, which separates the mapped bits from the unmapped ones.

The lock is set from a disabled state, which shows that the lock alone forces wd_enable. Clearing and rewrite attempts then show that it is sticky and that it freezes the register. Two resets with different non-volatile images finish the run. They show that only reset clears the lock, and that the lock and the permits load directly from the image.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int REG_W     = 8;
  localparam int LOCK_BIT  = 7;
  localparam int WIN_BIT   = 2;
  localparam int EN_BIT    = 1;
  localparam int BUSY_BIT  = 7;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
endpackage

// File: rtl/wdc_sync.sv
module wdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdc_regs.sv
module wdc_regs
  import wdc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  nvm_ctrl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ack_sync,
  output logic              req_tgl,
  output logic              sent_val,
  output logic              lock,
  output logic              en,
  output logic              win,
  output logic              syncbusy,
  output logic              cfg_perm,
  output logic              ew_perm
);
  logic lock_q, en_q, win_q, req_q, sent_q;
  logic lock_d, en_d, win_d;
  logic ctrl_sel, eff, hs_busy, pend, busy;
  logic [REG_W-1:0] ctrl_img, stat_img;

  always_comb begin
    ctrl_sel = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    eff      = lock_q | en_q;
    hs_busy  = req_q ^ ack_sync;
    pend     = eff ^ sent_q;
    busy     = hs_busy | pend;
    lock_d   = lock_q | (ctrl_sel & bus_wdata[LOCK_BIT]);
    win_d    = (ctrl_sel && !lock_q) ? bus_wdata[WIN_BIT] : win_q;
    en_d     = (ctrl_sel && !lock_q && !busy) ? bus_wdata[EN_BIT] : en_q;
    ctrl_img = '0;
    ctrl_img[LOCK_BIT] = lock_q;
    ctrl_img[WIN_BIT]  = win_q;
    ctrl_img[EN_BIT]   = en_q;
    stat_img = '0;
    stat_img[BUSY_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= nvm_ctrl[LOCK_BIT];
      win_q     <= nvm_ctrl[WIN_BIT];
      en_q      <= nvm_ctrl[EN_BIT];
      req_q     <= 1'b0;
      sent_q    <= 1'b0;
      bus_rdata <= '0;
      cfg_perm  <= ~nvm_ctrl[LOCK_BIT];
      ew_perm   <= ~nvm_ctrl[LOCK_BIT];
    end else begin
      lock_q   <= lock_d;
      win_q    <= win_d;
      en_q     <= en_d;
      cfg_perm <= ~lock_d;
      ew_perm  <= ~lock_d;
      if (!hs_busy && pend) begin
        req_q  <= ~req_q;
        sent_q <= eff;
      end
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(CTRL_ADDR))      bus_rdata <= ctrl_img;
        else if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata <= stat_img;
        else                                     bus_rdata <= '0;
      end
    end
  end

  assign req_tgl  = req_q;
  assign sent_val = sent_q;
  assign lock     = lock_q;
  assign en       = en_q;
  assign win      = win_q;
  assign syncbusy = busy;
endmodule

// File: rtl/wdc_wd_capture.sv
module wdc_wd_capture #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_tgl,
  input  logic data_in,
  output logic wd_en,
  output logic ack_tgl
);
  logic req_s, seen_q;

  wdc_sync #(.STAGES(STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tgl),
    .q   (req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      wd_en  <= 1'b0;
    end else if (req_s != seen_q) begin
      seen_q <= req_s;
      wd_en  <= data_in;
    end
  end

  assign ack_tgl = seen_q;
endmodule

// File: rtl/wdog_ctrl_front.sv
module wdog_ctrl_front
  import wdc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus,
  input  logic              clk_wd,
  input  logic              rst_wd,
  input  logic [REG_W-1:0]  nvm_ctrl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              wd_enable,
  output logic              wd_window,
  output logic              cfg_wr_permit,
  output logic              ew_wr_permit
);
  logic req_tgl, sent_val, ack_tgl, ack_sync;
  logic lock_w, en_w, win_w, busy_w;

  wdc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk_bus),
    .rst       (rst_bus),
    .nvm_ctrl  (nvm_ctrl),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ack_sync  (ack_sync),
    .req_tgl   (req_tgl),
    .sent_val  (sent_val),
    .lock      (lock_w),
    .en        (en_w),
    .win       (win_w),
    .syncbusy  (busy_w),
    .cfg_perm  (cfg_wr_permit),
    .ew_perm   (ew_wr_permit)
  );

  wdc_wd_capture #(.STAGES(STAGES)) u_wd (
    .clk     (clk_wd),
    .rst     (rst_wd),
    .req_tgl (req_tgl),
    .data_in (sent_val),
    .wd_en   (wd_enable),
    .ack_tgl (ack_tgl)
  );

  wdc_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk (clk_bus),
    .rst (rst_bus),
    .d   (ack_tgl),
    .q   (ack_sync)
  );

  assign wd_window = win_w;
endmodule

// File: rtl/wdc_front_chk.sv
module wdc_front_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic              rd,
  input logic [7:0]        rdata,
  input logic              lock,
  input logic              en,
  input logic              win,
  input logic              busy,
  input logic              cfg_perm,
  input logic              ew_perm
);
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  a_r5_permit_low: assert property (@(posedge clk) disable iff (rst)
    lock |-> (!cfg_perm && !ew_perm));

  a_r5_permit_high: assert property (@(posedge clk) disable iff (rst)
    !lock |-> (cfg_perm && ew_perm));

  a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock && wr && addr == ADDR_W'(0)) |=> ($stable(en) && $stable(win)));

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && wr && addr == ADDR_W'(0)) |=> $stable(en));

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(0)) |=> ((rdata & 8'h79) == 8'h00));

  a_r7_status_low: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(1)) |=> (rdata[6:0] == 7'd0));
endmodule

bind wdog_ctrl_front wdc_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk_bus),
  .rst      (rst_bus),
  .addr     (bus_addr),
  .wr       (bus_wr),
  .rd       (bus_rd),
  .rdata    (bus_rdata),
  .lock     (lock_w),
  .en       (en_w),
  .win      (win_w),
  .busy     (busy_w),
  .cfg_perm (cfg_wr_permit),
  .ew_perm  (ew_wr_permit)
);

// File: tb/test_wdog_ctrl_front.sv
module test_wdog_ctrl_front;
  logic       clk_bus = 1'b0, clk_wd = 1'b0;
  logic       rst_bus = 1'b1, rst_wd = 1'b1;
  logic [7:0] nvm_ctrl = 8'h06;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wd_enable, wd_window, cfg_wr_permit, ew_wr_permit;

  int vectors = 0, errors = 0;
  int wd_cnt = 0;
  logic       rd_d = 1'b0;
  logic [7:0] last_rd = '0;

  typedef struct {
    logic       chk;
    logic [7:0] exp;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #5    clk_bus = ~clk_bus;
  always #18.5 clk_wd  = ~clk_wd;

  always @(posedge clk_wd)  wd_cnt <= wd_cnt + 1;
  always @(posedge clk_bus) rd_d   <= bus_rd;

  wdog_ctrl_front i_wdog_ctrl_front (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_wd(clk_wd), .rst_wd(rst_wd),
    .nvm_ctrl(nvm_ctrl), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wd_enable(wd_enable), .wd_window(wd_window),
    .cfg_wr_permit(cfg_wr_permit), .ew_wr_permit(ew_wr_permit)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk_bus) begin
    if (rd_d) begin
      last_rd = bus_rdata;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk) check(e.req, bus_rdata, e.exp);
      end
    end
  end

  task automatic do_reset(logic [7:0] img);
    @(negedge clk_bus);
    nvm_ctrl = img; rst_bus = 1'b1; rst_wd = 1'b1;
    repeat (4) @(negedge clk_wd);
    @(negedge clk_bus);
    rst_bus = 1'b0; rst_wd = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_wr = 1'b0;
  endtask

  task automatic rd_push(logic [1:0] a, logic chk, logic [7:0] exp, string req);
    exp_t e;
    e.chk = chk; e.exp = exp; e.req = req;
    @(negedge clk_bus);
    sb_q.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk_bus);
    bus_rd = 1'b0;
    #1;
  endtask

  // polls status until SYNCBUSY drops; bound in watchdog cycles (R9)
  task automatic wait_idle(string req);
    int start;
    bit done;
    start = wd_cnt;
    done  = 1'b0;
    for (int i = 0; i < 200; i++) begin
      rd_push(2'd1, 1'b0, 8'h00, req);
      if (!last_rd[7]) begin done = 1'b1; break; end
    end
    vectors++;
    if (!done || (wd_cnt - start) > 8) begin
      errors++;
      $display("FAIL %s: busy for %0d wd cycles (done=%0d) expected <= 8",
               req, wd_cnt - start, done);
    end
  endtask

  task automatic chk_ports(string req, logic en, logic win, logic perm);
    @(negedge clk_bus);
    check(req, {7'd0, wd_enable}, {7'd0, en});
    check(req, {7'd0, wd_window}, {7'd0, win});
    check(req, {6'd0, cfg_wr_permit, ew_wr_permit}, {6'd0, perm, perm});
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R2 reset loads image 0x06
    do_reset(8'h06);
    rd_push(2'd0, 1'b1, 8'h06, "R2 ctrl after reset");
    wait_idle("R9 initial transfer");
    chk_ports("R2 ports after reset", 1'b1, 1'b1, 1'b1);

    // R7 readback and busy, R9 completion
    wr(2'd0, 8'h04);
    rd_push(2'd0, 1'b1, 8'h04, "R7 ctrl readback");
    rd_push(2'd1, 1'b1, 8'h80, "R7 syncbusy set");
    wait_idle("R9 disable transfer");
    chk_ports("R9 wd_enable off", 1'b0, 1'b1, 1'b1);

    // R6 second write while busy dropped
    wr(2'd0, 8'h06);
    wr(2'd0, 8'h04);
    rd_push(2'd0, 1'b1, 8'h06, "R6 write during busy ignored");
    wait_idle("R9 enable transfer");
    chk_ports("R6 wd_enable on", 1'b1, 1'b1, 1'b1);

    // R8 window-only write, no transfer
    wr(2'd0, 8'h02);
    rd_push(2'd0, 1'b1, 8'h02, "R8 window cleared");
    rd_push(2'd1, 1'b1, 8'h00, "R7 no busy without change");
    chk_ports("R8 normal mode", 1'b1, 1'b0, 1'b1);

    // R1 reserved bits and unmapped address
    wr(2'd0, 8'h7B);
    rd_push(2'd0, 1'b1, 8'h02, "R1 reserved bits");
    rd_push(2'd2, 1'b1, 8'h00, "R1 unmapped address");

    // R4 lock forces enable from disabled state
    wr(2'd0, 8'h00);
    wait_idle("R9 disable before lock");
    chk_ports("R4 disabled before lock", 1'b0, 1'b0, 1'b1);
    wr(2'd0, 8'h80);
    rd_push(2'd0, 1'b1, 8'h80, "R3 lock set");
    rd_push(2'd1, 1'b1, 8'h80, "R4 lock starts transfer");
    wait_idle("R9 lock transfer");
    chk_ports("R4 R5 locked", 1'b1, 1'b0, 1'b0);

    // R3 sticky, R5 frozen
    wr(2'd0, 8'h00);
    rd_push(2'd0, 1'b1, 8'h80, "R3 write zero no effect");
    wr(2'd0, 8'h06);
    rd_push(2'd0, 1'b1, 8'h80, "R5 ctrl frozen");
    chk_ports("R5 window frozen", 1'b1, 1'b0, 1'b0);

    // R3 reset clears lock
    do_reset(8'h00);
    rd_push(2'd0, 1'b1, 8'h00, "R3 reset clears lock");
    wait_idle("R9 after reset");
    chk_ports("R3 R5 unlocked after reset", 1'b0, 1'b0, 1'b1);

    // R2 lock from image
    do_reset(8'h82);
    rd_push(2'd0, 1'b1, 8'h82, "R2 lock from image");
    chk_ports("R2 R5 permits low from image", wd_enable, 1'b0, 1'b0);
    wr(2'd0, 8'h00);
    rd_push(2'd0, 1'b1, 8'h82, "R3 image lock sticky");
    wait_idle("R9 image lock transfer");
    chk_ports("R4 image lock enable", 1'b1, 1'b0, 1'b0);

    repeat (4) @(negedge clk_bus);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule